// File: doc/BRIEF.md
# PIO Sector Command Sequencer

This block is the device-side control engine for programmed-I/O disk commands. A register front end passes it an opcode strobe with the command byte, and the block then drives the handshake bits the host watches: busy while the device works on the media, a data-request window while the host moves words through the data port, and a pending-interrupt flag for the interrupt unit. It recognises read, write, verify, format-track, identify and no-data positioning commands. It rejects every other opcode with an abort status.

Media work is modelled as a request/done handshake to a sector buffer port. While busy, the block holds `buf_req` high and shows the direction on `buf_dir`. A one-cycle `buf_done` pulse tells it that the buffer has been filled for the host or drained to the media. Within each data-request window the block counts a parameterised number of words, 256 by default, and shows the index of the next word on `word_idx`. The sector count register is also the remaining-sector counter. A stored zero stands for 256 sectors, and the register steps down once for each finished sector.

A command byte is taken only when the block is idle and `dev_sel` equals the `DEV_ID` parameter. The host may load the sector count only while the block is idle.

Top module: `pio_xfer_seq`

## Requirements
- R1: After reset the block reads sector count 1, `drdy` 1 and `busy`, `drq`, `err`, `abrt`, `irq_pend` all 0.
- R2: Opcodes 20h/21h (read), 30h/31h (write), 40h/41h (verify), 50h (format), ECh (identify), 91h, 1xh and 7xh (no-data) are valid. Any other byte sets `err` and `abrt` and `irq_pend` on the next cycle, with `busy` and `drq` staying 0 and `drdy` unchanged.
- R3: A command strobe is ignored when `dev_sel` differs from `DEV_ID`, or while `busy` or `drq` is 1. A sector count write is ignored while `busy` or `drq` is 1.
- R4: Read and identify raise `busy` and `buf_req` with `buf_dir`=0 in the cycle after the strobe. `busy` and `drq` are never 1 together.
- R5: Every data-request window lasts exactly WORDS accepted data strobes. `word_idx` is 0 at the start of each window and rises by one per accepted strobe.
- R6: Each finished sector of a read, write or verify lowers the sector count by one, wrapping 0 to 255. A command ends after the sector finished while the count was 1, so a stored 0 runs 256 sectors and the count ends at 0.
- R7: Write raises `drq` in the cycle after the strobe without an interrupt. After the last word of a window, `busy` with `buf_dir`=1 follows. Each `buf_done` then opens the next window with `irq_pend`, or ends the command with `irq_pend`.
- R8: Format track (50h) opens one data window at once, then a busy store phase, then completes with `irq_pend`. It leaves the sector count unchanged.
- R9: Identify (ECh) runs one busy fetch, then one data window opened together with `irq_pend`. It leaves the sector count unchanged.
- R10: Verify stays busy with no data window and consumes one `buf_done` per sector. 91h, 1xh and 7xh take a single `buf_done` and leave the count unchanged. Both end with `irq_pend`.
- R11: A valid command clears `drdy`, `err` and `abrt`. On completion `busy` and `drq` are 0 and `drdy` is 1. The end of the last read or identify window raises no interrupt.
- R12: `stat_rd` and a valid command strobe clear `irq_pend`. A raising event in the same cycle wins.
- R13: `data_rd` counts only in a host-read window, `data_wr` only in a host-write window, and `buf_done` only while `busy`. Otherwise they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| dev_sel | input | 1 | Drive-select bit from the drive/head register |
| sc_we | input | 1 | Host write strobe for the sector count |
| sc_wdata | input | 8 | Sector count write value |
| data_rd | input | 1 | Host read of one data word |
| data_wr | input | 1 | Host write of one data word |
| stat_rd | input | 1 | Host read of the status register |
| buf_done | input | 1 | Sector buffer finished the requested fill or drain |
| sc_value | output | 8 | Sector count register (0 means 256) |
| word_idx | output | IW | Index of the next data word in the window |
| buf_req | output | 1 | Request to the sector buffer port |
| buf_dir | output | 1 | 0 = fill buffer for host, 1 = drain buffer to media |
| busy | output | 1 | Device owns the register file |
| drq | output | 1 | Data window open |
| drdy | output | 1 | Ready to accept a command |
| err | output | 1 | Last command ended in error |
| abrt | output | 1 | Last command was aborted |
| irq_pend | output | 1 | Interrupt pending toward the interrupt unit |

## Verification
The assertions assume that `buf_done` arrives as a single-cycle pulse and that the host strobes at most one data word per cycle. The stimulus keeps to both rules. The service task pulses `buf_done` once after a fixed wait in each busy phase and raises at most one strobe per cycle. It also drives wrong-direction strobes, and `data_rd` or `data_wr` during busy phases, so that the ignore rules are exercised. Command bytes and sector count writes sent during an open data window check that a running command is not disturbed.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [2:0] {
    CL_READ, CL_WRITE, CL_VERIFY, CL_FORMAT, CL_IDENT, CL_NODATA, CL_BAD
  } op_class_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_HOST_RD, PH_HOST_WR, PH_STORE, PH_MEDIA
  } phase_e;

  // Map a command byte onto the class that picks the phase sequence.
  function automatic op_class_e classify(input logic [7:0] op);
    op_class_e c;
    casez (op)
      8'h20, 8'h21:            c = CL_READ;
      8'h30, 8'h31:            c = CL_WRITE;
      8'h40, 8'h41:            c = CL_VERIFY;
      8'h50:                   c = CL_FORMAT;
      8'hEC:                   c = CL_IDENT;
      8'h91:                   c = CL_NODATA;
      8'b0001_????:            c = CL_NODATA;
      8'b0111_????:            c = CL_NODATA;
      default:                 c = CL_BAD;
    endcase
    return c;
  endfunction

  // The register holds the sectors still to move; zero encodes 256,
  // so the command ends on the sector finished while it reads one.
  function automatic logic is_final_sector(input logic [7:0] sc);
    return sc == 8'd1;
  endfunction

  function automatic logic [7:0] sc_after_sector(input logic [7:0] sc);
    return sc - 8'd1;
  endfunction

  function automatic logic host_reads(input op_class_e c);
    return (c == CL_READ) || (c == CL_IDENT);
  endfunction

  function automatic logic host_writes(input op_class_e c);
    return (c == CL_WRITE) || (c == CL_FORMAT);
  endfunction

endpackage

// File: rtl/pio_op_decode.sv
module pio_op_decode
  import pio_seq_pkg::*;
#(
  parameter bit DEV_ID = 1'b0
) (
  input  logic       strobe,
  input  logic       ready,
  input  logic [7:0] code,
  input  logic       dev_sel,
  output logic       take,
  output logic       refuse,
  output op_class_e  cls
);

  logic mine;

  assign cls    = classify(code);
  assign mine   = strobe && ready && (dev_sel == DEV_ID);
  assign take   = mine && (cls != CL_BAD);
  assign refuse = mine && (cls == CL_BAD);

endmodule

// File: rtl/pio_word_ctr.sv
module pio_word_ctr #(
  parameter int unsigned WORDS = 256,
  localparam int CW = $clog2(WORDS + 1),
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic          last,
  output logic [IW-1:0] idx
);

  logic [CW-1:0] left_q;

  function automatic logic [IW-1:0] word_index(input logic [CW-1:0] left);
    logic [CW-1:0] done;
    done = CW'(WORDS) - left;
    return done[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                      left_q <= '0;
    else if (load)                   left_q <= CW'(WORDS);
    else if (step && left_q != '0)   left_q <= left_q - CW'(1);
  end

  assign last = (left_q == CW'(1));
  assign idx  = word_index(left_q);

  AST_WORD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0) && !last) else $error("word reload");            // R5
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !last) |=> idx == $past(idx) + IW'(1)) else $error("word step"); // R5

endmodule

// File: rtl/pio_sc_reg.sv
module pio_sc_reg
  import pio_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_ok,
  input  logic [7:0] host_data,
  input  logic       step,
  output logic [7:0] sc,
  output logic       final_sec
);

  logic [7:0] sc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   sc_q <= 8'd1;
    else if (step)                sc_q <= sc_after_sector(sc_q);
    else if (host_we && host_ok)  sc_q <= host_data;
  end

  assign sc        = sc_q;
  assign final_sec = is_final_sector(sc_q);

  AST_SC_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_ok && !step) |=> sc == $past(sc)) else $error("sc write leak"); // R3

endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned WORDS  = 256,
  parameter bit          DEV_ID = 1'b0,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic          dev_sel,
  input  logic          sc_we,
  input  logic [7:0]    sc_wdata,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic          stat_rd,
  input  logic          buf_done,
  output logic [7:0]    sc_value,
  output logic [IW-1:0] word_idx,
  output logic          buf_req,
  output logic          buf_dir,
  output logic          busy,
  output logic          drq,
  output logic          drdy,
  output logic          err,
  output logic          abrt,
  output logic          irq_pend
);

  phase_e    ph_q, ph_n;
  op_class_e cls_q, cls_dec;

  logic idle, accept, reject;
  logic rd_word, wr_word, wc_last, wc_load;
  logic blk_out_end, blk_in_end, media_ack;
  logic sec_done, final_sec, cmd_end, irq_set, irq_clr;
  logic drdy_q, err_q, irq_q;

  assign idle = (ph_q == PH_IDLE);

  pio_op_decode #(.DEV_ID(DEV_ID)) u_dec (
    .strobe (cmd_we),
    .ready  (idle),
    .code   (cmd_code),
    .dev_sel(dev_sel),
    .take   (accept),
    .refuse (reject),
    .cls    (cls_dec)
  );

  // Named internal events
  assign rd_word     = (ph_q == PH_HOST_RD) && data_rd;
  assign wr_word     = (ph_q == PH_HOST_WR) && data_wr;
  assign blk_out_end = rd_word && wc_last;
  assign blk_in_end  = wr_word && wc_last;
  assign media_ack   = buf_done &&
                       (ph_q == PH_FETCH || ph_q == PH_STORE || ph_q == PH_MEDIA);

  assign sec_done = (blk_out_end && cls_q == CL_READ) ||
                    (ph_q == PH_STORE && buf_done && cls_q == CL_WRITE) ||
                    (ph_q == PH_MEDIA && buf_done && cls_q == CL_VERIFY);

  pio_word_ctr #(.WORDS(WORDS)) u_words (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wc_load),
    .step (rd_word || wr_word),
    .last (wc_last),
    .idx  (word_idx)
  );

  pio_sc_reg u_sc (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (sc_we),
    .host_ok  (idle),
    .host_data(sc_wdata),
    .step     (sec_done),
    .sc       (sc_value),
    .final_sec(final_sec)
  );

  // Phase sequencing
  always_comb begin
    ph_n = ph_q;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        if (host_reads(cls_dec))       ph_n = PH_FETCH;
        else if (host_writes(cls_dec)) ph_n = PH_HOST_WR;
        else                           ph_n = PH_MEDIA;
      end
      PH_FETCH:   if (buf_done) ph_n = PH_HOST_RD;
      PH_HOST_RD: if (blk_out_end)
                    ph_n = (cls_q == CL_READ && !final_sec) ? PH_FETCH : PH_IDLE;
      PH_HOST_WR: if (blk_in_end) ph_n = PH_STORE;
      PH_STORE:   if (buf_done)
                    ph_n = (cls_q == CL_WRITE && !final_sec) ? PH_HOST_WR : PH_IDLE;
      PH_MEDIA:   if (buf_done)
                    ph_n = (cls_q == CL_VERIFY && !final_sec) ? PH_MEDIA : PH_IDLE;
      default:    ph_n = PH_IDLE;
    endcase
  end

  assign cmd_end = !idle && (ph_n == PH_IDLE);
  assign wc_load = (accept && host_writes(cls_dec)) ||
                   (ph_q == PH_FETCH && buf_done) ||
                   (ph_q == PH_STORE && buf_done && ph_n == PH_HOST_WR);

  assign irq_set = reject ||
                   (ph_q == PH_FETCH && buf_done) ||
                   (ph_q == PH_STORE && buf_done) ||
                   (ph_q == PH_MEDIA && buf_done && ph_n == PH_IDLE);
  assign irq_clr = stat_rd || accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cls_q  <= CL_NODATA;
      drdy_q <= 1'b1;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ph_q <= ph_n;
      if (accept) cls_q <= cls_dec;
      if (accept)       drdy_q <= 1'b0;
      else if (cmd_end) drdy_q <= 1'b1;
      if (reject)       err_q <= 1'b1;
      else if (accept)  err_q <= 1'b0;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign busy     = (ph_q == PH_FETCH) || (ph_q == PH_STORE) || (ph_q == PH_MEDIA);
  assign drq      = (ph_q == PH_HOST_RD) || (ph_q == PH_HOST_WR);
  assign buf_req  = busy;
  assign buf_dir  = (ph_q == PH_STORE);
  assign drdy     = drdy_q;
  assign err      = err_q;
  assign abrt     = err_q;
  assign irq_pend = irq_q;

  AST_BUSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && drq)) else $error("busy with drq");                                   // R4
  AST_BAD_OP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err && abrt && irq_pend && !busy && !drq) else $error("abort");      // R2
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && idle && dev_sel != DEV_ID) |=> !busy && !drq) else $error("foreign"); // R3
  AST_SC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !sec_done) |=> $stable(sc_value)) else $error("sc moved");            // R3
  AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_done |=> sc_value == $past(sc_value) - 8'd1) else $error("sc step");        // R6
  AST_FINISH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> drdy && !busy && !drq) else $error("finish");                       // R11
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !irq_pend) else $error("irq ack");                    // R12
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !busy && !cmd_we) |=> $stable(busy) && $stable(drq)) else $error("stray done"); // R13

endmodule

// File: tb/pio_xfer_seq_test.sv
module pio_xfer_seq_test;

  localparam int W  = 256;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, dev_sel = 0, sc_we = 0, data_rd = 0, data_wr = 0;
  logic stat_rd = 0, buf_done = 0;
  logic [7:0] cmd_code = 8'h00, sc_wdata = 8'h00;
  logic [7:0] sc_value;
  logic [IW-1:0] word_idx;
  logic buf_req, buf_dir, busy, drq, drdy, err, abrt, irq_pend;

  int checks = 0, fails = 0;
  bit cmp_en = 0;

  always #4 clk = ~clk;

  pio_xfer_seq #(.WORDS(W), .DEV_ID(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .dev_sel(dev_sel), .sc_we(sc_we), .sc_wdata(sc_wdata),
    .data_rd(data_rd), .data_wr(data_wr), .stat_rd(stat_rd),
    .buf_done(buf_done), .sc_value(sc_value), .word_idx(word_idx),
    .buf_req(buf_req), .buf_dir(buf_dir), .busy(busy), .drq(drq),
    .drdy(drdy), .err(err), .abrt(abrt), .irq_pend(irq_pend)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 fetch, 2 host reads, 3 host writes,
  // 4 store, 5 media-only.  Kind 0 bad, 1 read, 2 write, 3 verify,
  // 4 format, 5 identify, 6 no-data.
  int mph, mkind, msc, mleft;
  bit mdrdy, merr, mirq;

  function automatic int kind_of(input logic [7:0] c);
    if (c == 8'h20 || c == 8'h21) return 1;
    if (c == 8'h30 || c == 8'h31) return 2;
    if (c == 8'h40 || c == 8'h41) return 3;
    if (c == 8'h50) return 4;
    if (c == 8'hEC) return 5;
    if (c == 8'h91 || c[7:4] == 4'h1 || c[7:4] == 4'h7) return 6;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int nph, nsc, rem, k;
    bit setq, clrq;
    if (!rst_n) begin
      mph = 0; mkind = 6; msc = 1; mleft = 0; mdrdy = 1; merr = 0; mirq = 0;
    end else begin
      nph = mph; nsc = msc; setq = 0; clrq = 0;
      rem = (msc == 0) ? 256 : msc;
      case (mph)
        0: begin
          if (sc_we) nsc = sc_wdata;
          if (cmd_we && dev_sel == 1'b0) begin
            k = kind_of(cmd_code);
            if (k == 0) begin merr = 1; setq = 1; end
            else begin
              merr = 0; clrq = 1; mdrdy = 0; mkind = k;
              if (k == 1 || k == 5) nph = 1;
              else if (k == 2 || k == 4) begin nph = 3; mleft = W; end
              else nph = 5;
            end
          end
        end
        1: if (buf_done) begin nph = 2; mleft = W; setq = 1; end
        2: if (data_rd) begin
          mleft--;
          if (mleft == 0) begin
            if (mkind == 1) begin nsc = rem - 1; nph = (rem == 1) ? 0 : 1; end
            else nph = 0;
          end
        end
        3: if (data_wr) begin mleft--; if (mleft == 0) nph = 4; end
        4: if (buf_done) begin
          setq = 1;
          if (mkind == 2) begin
            nsc = rem - 1;
            if (rem == 1) nph = 0; else begin nph = 3; mleft = W; end
          end else nph = 0;
        end
        5: if (buf_done) begin
          if (mkind == 3) begin
            nsc = rem - 1;
            if (rem == 1) begin nph = 0; setq = 1; end
          end else begin nph = 0; setq = 1; end
        end
        default: nph = 0;
      endcase
      if (mph != 0 && nph == 0) mdrdy = 1;
      if (stat_rd) clrq = 1;
      if (setq) mirq = 1; else if (clrq) mirq = 0;
      mph = nph; msc = nsc & 255;
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R4", "busy", busy, (mph == 1 || mph == 4 || mph == 5));
      chk("R5", "drq", drq, (mph == 2 || mph == 3));
      chk("R4", "buf_req", buf_req, (mph == 1 || mph == 4 || mph == 5));
      chk("R7", "buf_dir", buf_dir, (mph == 4));
      chk("R6", "sc_value", sc_value, msc);
      chk("R11", "drdy", drdy, mdrdy);
      chk("R2", "err", err, merr);
      chk("R2", "abrt", abrt, merr);
      chk("R12", "irq_pend", irq_pend, mirq);
      if (mph == 2 || mph == 3) chk("R5", "word_idx", word_idx, W - mleft);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic issue(input logic [7:0] code, input logic sel);
    @(negedge clk); cmd_code = code; dev_sel = sel; cmd_we = 1;
    @(negedge clk); cmd_we = 0; dev_sel = 0;
  endtask

  task automatic set_sc(input logic [7:0] v);
    @(negedge clk); sc_we = 1; sc_wdata = v;
    @(negedge clk); sc_we = 0;
  endtask

  // Host plus media agent: services until idle; stray strobes included (R13).
  task automatic service(input bit rd_side, output int media_n, output int words_n);
    int wait_c = 0, k = 0;
    media_n = 0; words_n = 0;
    while (busy || drq) begin
      buf_done = 0; data_rd = 0; data_wr = 0;
      if (busy) begin
        data_rd = 1; data_wr = 1;
        wait_c++;
        if (wait_c == 3) begin buf_done = 1; wait_c = 0; media_n++; end
      end else begin
        k++;
        if (k % 5 != 0) begin
          if (rd_side) data_rd = 1; else data_wr = 1;
          words_n++;
        end else begin
          if (rd_side) data_wr = 1; else data_rd = 1;
        end
      end
      @(negedge clk);
    end
    buf_done = 0; data_rd = 0; data_wr = 0;
  endtask

  initial begin
    int m, wn;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_en = 1;
    @(negedge clk);
    chk("R1", "reset sc", sc_value, 1);
    chk("R1", "reset drdy", drdy, 1);
    chk("R1", "reset busy|drq|err|abrt|irq", busy | drq | err | abrt | irq_pend, 0);

    issue(8'hA5, 1'b0);
    chk("R2", "bad opcode err", err, 1);
    chk("R2", "bad opcode abrt", abrt, 1);
    chk("R2", "bad opcode no busy", busy | drq, 0);
    chk("R12", "bad opcode irq", irq_pend, 1);

    // read 3 sectors
    set_sc(8'd3);
    issue(8'h20, 1'b0);
    chk("R4", "read busy", busy, 1);
    chk("R4", "read dir", buf_dir, 0);
    chk("R11", "read clears err", err, 0);
    chk("R11", "read clears drdy", drdy, 0);
    service(1'b1, m, wn);
    chk("R4", "read fetches", m, 3);
    chk("R5", "read words", wn, 3 * W);
    chk("R6", "read sc end", sc_value, 0);
    chk("R11", "read end drdy", drdy, 1);

    // foreign drive, then stray buf_done while idle
    issue(8'h21, 1'b1);
    chk("R3", "foreign busy", busy | drq, 0);
    @(negedge clk); buf_done = 1; @(negedge clk); buf_done = 0;
    chk("R13", "idle buf_done", busy | drq, 0);

    // write 2 sectors, with ignored command and sc write in the window
    set_sc(8'd2);
    issue(8'h30, 1'b0);
    chk("R7", "write drq", drq, 1);
    chk("R7", "write no irq", irq_pend, 0);
    cmd_code = 8'h20; cmd_we = 1; sc_we = 1; sc_wdata = 8'd9;
    @(negedge clk); cmd_we = 0; sc_we = 0;
    chk("R3", "sc write in window", sc_value, 2);
    chk("R3", "cmd in window", drq, 1);
    service(1'b0, m, wn);
    chk("R7", "write stores", m, 2);
    chk("R5", "write words", wn, 2 * W);
    chk("R6", "write sc end", sc_value, 0);
    chk("R7", "write end irq", irq_pend, 1);

    // format
    set_sc(8'd7);
    issue(8'h50, 1'b0);
    chk("R8", "format drq", drq, 1);
    service(1'b0, m, wn);
    chk("R8", "format store", m, 1);
    chk("R8", "format sc kept", sc_value, 7);
    chk("R8", "format irq", irq_pend, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk("R12", "stat read clears", irq_pend, 0);

    // identify
    issue(8'hEC, 1'b0);
    chk("R9", "ident busy", busy, 1);
    service(1'b1, m, wn);
    chk("R9", "ident words", wn, W);
    chk("R9", "ident sc kept", sc_value, 7);

    // verify 256 sectors
    set_sc(8'd0);
    issue(8'h41, 1'b0);
    service(1'b1, m, wn);
    chk("R10", "verify 256 acks", m, 256);
    chk("R10", "verify no words", wn, 0);
    chk("R6", "verify sc end", sc_value, 0);
    chk("R10", "verify irq", irq_pend, 1);

    // seek
    set_sc(8'd5);
    issue(8'h7A, 1'b0);
    service(1'b1, m, wn);
    chk("R10", "seek acks", m, 1);
    chk("R10", "seek sc kept", sc_value, 5);
    chk("R11", "seek drdy", drdy, 1);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule